// File: doc/BRIEF.md
# Multiplexed Asynchronous Bus Target

This block is the target side of a backplane bus whose address and data travel on one shared set of lines. A master opens each cycle by putting a 22-bit byte address on the lines and raising the cycle strobe. At that moment the target latches the address together with the I/O-bank select and the cycle qualifiers. It then answers the data phases that follow on the same lines, using a small file of 16-bit registers that sits in the I/O page.

Timing is set entirely by the master's strobes. The target raises its reply only after it sees a read or write strobe, holds the reply while that strobe stays high, and drops it once the strobe is released. The target never times out a cycle. The target supports word reads, word writes, byte writes, read-modify-write within a single address phase, and block mode, where one address phase is followed by data phases at consecutive word addresses. Interrupt-acknowledge cycles and cycles outside the target's window get no reply, so another device can answer them.

All strobes are expected to arrive already synchronised to `clk`. The target registers its reply and its read data, so both appear one clock after the target samples a strobe.

Top module: `muxbus_target`

## Requirements
- R1: After reset `reply_o` and `bus_oe_o` are low and every register reads as 0x0000.
- R2: The address and qualifiers are captured on the clock where `sync_i` is first seen high. The cycle belongs to this target only if `iobank_i` was high and the byte address lies in [BASE, BASE+2*NREGS). Otherwise no data strobe ever raises `reply_o` and no register changes.
- R3: A cycle captured with `iack_i` high gets no reply, even when its address is inside the window, and a write strobe in it changes no register.
- R4: A read strobe in a claimed cycle puts the register at word offset (addr-BASE)>>1 on `bus_dout_o`, ignoring address bit 0, with `bus_oe_o` and `reply_o` high one clock after the strobe is sampled. The reply stays high until the strobe is low and drops on the next clock.
- R5: A write strobe with `byte_i` low stores all 16 bits of `bus_ad_in[15:0]` in the addressed register.
- R6: A write strobe with `byte_i` high updates one byte only. If address bit 0 is 0, bits 7:0 are replaced by data bits 7:0. If it is 1, bits 15:8 are replaced by data bits 15:8. The other byte keeps its value.
- R7: Within one address phase, a read phase followed by a write phase, with no new address, both target the same register (read-modify-write). The read returns the old value and the write stores the new one.
- R8: When `burst_i` is high at address capture, each completed data phase moves the target to the next word register for the following phase.
- R9: A burst that advances past the last register gets no reply for the remaining data phases, and those phases change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ad_in | input | 22 | Shared lines: byte address in the address phase, write data in bits 15:0 in write phases |
| sync_i | input | 1 | Cycle strobe, high from the address phase to the end of the cycle |
| iobank_i | input | 1 | I/O-bank select, valid with the address |
| iack_i | input | 1 | Interrupt-acknowledge qualifier, valid with the address |
| burst_i | input | 1 | Block-mode qualifier, valid with the address |
| rd_strobe_i | input | 1 | Read data strobe from the master |
| wr_strobe_i | input | 1 | Write data strobe from the master |
| byte_i | input | 1 | Byte-write qualifier, valid with the write strobe |
| bus_dout_o | output | 16 | Read data driven to the shared lines |
| bus_oe_o | output | 1 | Output enable for `bus_dout_o` |
| reply_o | output | 1 | Reply handshake to the master |

## Verification
The hardest state to reach is a block-mode cycle whose internal word pointer has run past the last register. The target has to stay silent there while it is still inside a cycle it claimed. The stimulus starts bursts both at directed and at random register positions with random lengths, so that some data phases land beyond the file. Every register is then read back to confirm that none was touched. Read-modify-write cycles with byte writes in either lane are mixed into the random stream. This exercises the path where one address phase serves two phases of different direction.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  localparam int unsigned BUS_AW = 22;
  localparam int unsigned BUS_DW = 16;
  typedef enum logic [1:0] {PH_IDLE, PH_SEL, PH_RD, PH_WR} phase_t;
endpackage

// File: rtl/muxbus_decode.sv
module muxbus_decode #(
  parameter int unsigned AW = 22,
  parameter int unsigned NREGS = 8,
  parameter logic [AW-1:0] BASE = 22'h3FFF00,
  localparam int unsigned IW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch_i,
  input  logic          adv_i,
  input  logic [AW-1:0] ad_i,
  input  logic          iobank_i,
  input  logic          iack_i,
  input  logic          burst_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o,
  output logic          lane_o,
  output logic          burst_o,
  output logic [AW-1:0] woff_o
);
  // word offset of a byte address relative to the window base
  function automatic logic [AW-1:0] word_off(input logic [AW-1:0] a);
    logic [AW-1:0] d;
    d = a - BASE;
    return d >> 1;
  endfunction

  // cycle qualifies for this target before the range upper bound
  function automatic logic claims(input logic [AW-1:0] a, input logic iob, input logic ack);
    return iob && !ack && (a >= BASE);
  endfunction

  logic          sel_q;
  logic [AW-1:0] woff_q;
  logic          lane_q;
  logic          burst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      woff_q  <= '0;
      lane_q  <= 1'b0;
      burst_q <= 1'b0;
    end else if (latch_i) begin
      sel_q   <= claims(ad_i, iobank_i, iack_i);
      woff_q  <= word_off(ad_i);
      lane_q  <= ad_i[0];
      burst_q <= burst_i;
    end else if (adv_i) begin
      woff_q  <= woff_q + 1'b1;
    end
  end

  assign hit_o   = sel_q && (woff_q < AW'(NREGS));
  assign idx_o   = woff_q[IW-1:0];
  assign lane_o  = lane_q;
  assign burst_o = burst_q;
  assign woff_o  = woff_q;
endmodule

// File: rtl/muxbus_regs.sv
module muxbus_regs #(
  parameter int unsigned DW = 16,
  parameter int unsigned NREGS = 8,
  localparam int unsigned IW = $clog2(NREGS),
  localparam int unsigned NLANE = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [NLANE-1:0] be_i,
  input  logic [IW-1:0]    idx_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic [NLANE-1:0] be);
    logic [DW-1:0] r;
    for (int l = 0; l < int'(NLANE); l++)
      r[l*8 +: 8] = be[l] ? new_v[l*8 +: 8] : old_v[l*8 +: 8];
    return r;
  endfunction

  logic [DW-1:0] mem [NREGS];

  for (genvar g = 0; g < int'(NREGS); g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (we_i && (idx_i == IW'(g)))
        mem[g] <= lane_merge(mem[g], wdata_i, be_i);
    end
  end

  assign rdata_o = mem[idx_i];
endmodule

// File: rtl/muxbus_hs.sv
module muxbus_hs
  import muxbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic hit_i,
  input  logic burst_i,
  output logic latch_o,
  output logic acc_rd_o,
  output logic acc_wr_o,
  output logic adv_o,
  output logic reply_o,
  output logic oe_o
);
  phase_t state_q, state_d;
  logic   release_ev;

  assign latch_o    = (state_q == PH_IDLE) && sync_i;
  assign acc_rd_o   = (state_q == PH_SEL) && sync_i && hit_i && rd_i;
  assign acc_wr_o   = (state_q == PH_SEL) && sync_i && hit_i && !rd_i && wr_i;
  assign release_ev = ((state_q == PH_RD) && !rd_i) || ((state_q == PH_WR) && !wr_i);
  assign adv_o      = release_ev && burst_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PH_IDLE: if (sync_i) state_d = PH_SEL;
      PH_SEL: begin
        if (!sync_i)       state_d = PH_IDLE;
        else if (acc_rd_o) state_d = PH_RD;
        else if (acc_wr_o) state_d = PH_WR;
      end
      PH_RD, PH_WR: begin
        if (!sync_i)         state_d = PH_IDLE;
        else if (release_ev) state_d = PH_SEL;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  assign reply_o = (state_q == PH_RD) || (state_q == PH_WR);
  assign oe_o    = (state_q == PH_RD);
endmodule

// File: rtl/muxbus_target.sv
module muxbus_target
  import muxbus_pkg::*;
#(
  parameter int unsigned AW = BUS_AW,
  parameter int unsigned DW = BUS_DW,
  parameter int unsigned NREGS = 8,
  parameter logic [AW-1:0] BASE = 22'h3FFF00,
  localparam int unsigned IW = $clog2(NREGS),
  localparam int unsigned NLANE = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_ad_in,
  input  logic          sync_i,
  input  logic          iobank_i,
  input  logic          iack_i,
  input  logic          burst_i,
  input  logic          rd_strobe_i,
  input  logic          wr_strobe_i,
  input  logic          byte_i,
  output logic [DW-1:0] bus_dout_o,
  output logic          bus_oe_o,
  output logic          reply_o
);
  // lane enables for a write: all lanes, or the lane named by address bit 0
  function automatic logic [NLANE-1:0] byte_en(input logic is_byte, input logic lane);
    if (!is_byte) return '1;
    return NLANE'(1) << lane;
  endfunction

  logic          latch_ev, acc_rd_ev, acc_wr_ev, adv_ev, hit;
  logic [IW-1:0] idx;
  logic          lane, burst_q;
  logic [AW-1:0] woff;
  logic [DW-1:0] rdata;
  logic [DW-1:0] dout_q;

  muxbus_decode #(.AW(AW), .NREGS(NREGS), .BASE(BASE)) u_dec (
    .clk(clk), .rst_n(rst_n), .latch_i(latch_ev), .adv_i(adv_ev),
    .ad_i(bus_ad_in), .iobank_i(iobank_i), .iack_i(iack_i), .burst_i(burst_i),
    .hit_o(hit), .idx_o(idx), .lane_o(lane), .burst_o(burst_q), .woff_o(woff)
  );

  muxbus_hs u_hs (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .rd_i(rd_strobe_i),
    .wr_i(wr_strobe_i), .hit_i(hit), .burst_i(burst_q),
    .latch_o(latch_ev), .acc_rd_o(acc_rd_ev), .acc_wr_o(acc_wr_ev),
    .adv_o(adv_ev), .reply_o(reply_o), .oe_o(bus_oe_o)
  );

  muxbus_regs #(.DW(DW), .NREGS(NREGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(acc_wr_ev), .be_i(byte_en(byte_i, lane)),
    .idx_i(idx), .wdata_i(bus_ad_in[DW-1:0]), .rdata_o(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dout_q <= '0;
    else if (acc_rd_ev) dout_q <= rdata;
  end

  assign bus_dout_o = dout_q;
endmodule

// File: rtl/muxbus_chk.sv
module muxbus_chk #(
  parameter int unsigned AW = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_i,
  input logic          iobank_i,
  input logic          iack_i,
  input logic          rd_strobe_i,
  input logic          wr_strobe_i,
  input logic          reply_o,
  input logic          bus_oe_o,
  input logic          latch_ev,
  input logic          adv_ev,
  input logic          hit,
  input logic [AW-1:0] woff
);
  logic iack_seen, nobank_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iack_seen   <= 1'b0;
      nobank_seen <= 1'b0;
    end else if (latch_ev) begin
      iack_seen   <= iack_i;
      nobank_seen <= !iobank_i;
    end else if (!sync_i) begin
      iack_seen   <= 1'b0;
      nobank_seen <= 1'b0;
    end
  end

  a_r4_reply_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reply_o) |-> $past(rd_strobe_i || wr_strobe_i));
  a_r4_oe_only_with_reply: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |-> reply_o);
  a_r4_reply_release: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_o && !rd_strobe_i && !wr_strobe_i) |=> !reply_o);
  a_r3_iack_silent: assert property (@(posedge clk) disable iff (!rst_n)
    iack_seen |-> !reply_o);
  a_r2_nobank_silent: assert property (@(posedge clk) disable iff (!rst_n)
    nobank_seen |-> !reply_o);
  a_r9_reply_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reply_o) |-> $past(hit));
  a_r8_pointer_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |=> (woff == $past(woff) + 1'b1));
endmodule

bind muxbus_target muxbus_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .iobank_i(iobank_i), .iack_i(iack_i),
  .rd_strobe_i(rd_strobe_i), .wr_strobe_i(wr_strobe_i), .reply_o(reply_o),
  .bus_oe_o(bus_oe_o), .latch_ev(latch_ev), .adv_ev(adv_ev), .hit(hit), .woff(woff)
);

// File: tb/sim_muxbus_target.sv
module sim_muxbus_target;
  localparam int NR = 8;
  localparam logic [21:0] BASEA = 22'h3FFF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] bus_ad_in = '0;
  logic        sync_i = 0, iobank_i = 0, iack_i = 0, burst_i = 0;
  logic        rd_strobe_i = 0, wr_strobe_i = 0, byte_i = 0;
  logic [15:0] bus_dout_o;
  logic        bus_oe_o, reply_o;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit [15:0] model [NR];

  always #4 clk = ~clk;

  muxbus_target u0 (
    .clk(clk), .rst_n(rst_n), .bus_ad_in(bus_ad_in), .sync_i(sync_i),
    .iobank_i(iobank_i), .iack_i(iack_i), .burst_i(burst_i),
    .rd_strobe_i(rd_strobe_i), .wr_strobe_i(wr_strobe_i), .byte_i(byte_i),
    .bus_dout_o(bus_dout_o), .bus_oe_o(bus_oe_o), .reply_o(reply_o)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [21:0] reg_addr(input int i, input bit lane);
    return BASEA + 22'(2 * i) + 22'(lane);
  endfunction

  function automatic bit [15:0] merge_model(input bit [15:0] old_v, input bit [15:0] d,
                                            input bit is_byte, input bit lane);
    if (!is_byte) return d;
    if (lane) return {d[15:8], old_v[7:0]};
    return {old_v[15:8], d[7:0]};
  endfunction

  task automatic addr_phase(input logic [21:0] a, input bit iob, input bit ack, input bit bst);
    @(negedge clk);
    bus_ad_in = a; iobank_i = iob; iack_i = ack; burst_i = bst; sync_i = 1;
    @(negedge clk);
    iobank_i = 0; iack_i = 0; burst_i = 0; bus_ad_in = '0;
  endtask

  task automatic wait_reply(output bit seen);
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (reply_o) begin seen = 1; break; end
    end
  endtask

  task automatic rd_phase(input bit hit, input bit [15:0] exp, input string tag);
    bit seen;
    rd_strobe_i = 1;
    wait_reply(seen);
    chk(seen == hit, {tag, " reply"}, seen, hit);
    if (seen && hit) begin
      chk(bus_dout_o == exp, {tag, " data"}, bus_dout_o, exp);
      chk(bus_oe_o == 1'b1, {tag, " oe"}, bus_oe_o, 1);
    end
    rd_strobe_i = 0;
    @(negedge clk);
    chk(reply_o == 1'b0, {tag, " release"}, reply_o, 0);
  endtask

  task automatic wr_phase(input bit hit, input bit [15:0] d, input bit is_byte, input string tag);
    bit seen;
    bus_ad_in = {6'b0, d}; byte_i = is_byte; wr_strobe_i = 1;
    wait_reply(seen);
    chk(seen == hit, {tag, " reply"}, seen, hit);
    wr_strobe_i = 0; byte_i = 0; bus_ad_in = '0;
    @(negedge clk);
    chk(reply_o == 1'b0, {tag, " release"}, reply_o, 0);
  endtask

  task automatic end_cycle();
    sync_i = 0;
    @(negedge clk);
  endtask

  task automatic write_reg(input int i, input bit lane, input bit [15:0] d, input bit is_byte,
                           input string tag);
    addr_phase(reg_addr(i, lane), 1, 0, 0);
    wr_phase(1, d, is_byte, tag);
    end_cycle();
    model[i] = merge_model(model[i], d, is_byte, lane);
  endtask

  task automatic read_reg(input int i, input bit lane, input string tag);
    addr_phase(reg_addr(i, lane), 1, 0, 0);
    rd_phase(1, model[i], tag);
    end_cycle();
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < NR; i++) read_reg(i, 0, tag);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    for (int i = 0; i < NR; i++) model[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(reply_o == 1'b0, "R1 reply after reset", reply_o, 0);
    chk(bus_oe_o == 1'b0, "R1 oe after reset", bus_oe_o, 0);
    read_all("R1 reset value");

    // R5 word write, R4 read back with odd and even address
    write_reg(3, 0, 16'hA5C3, 0, "R5 word write");
    read_reg(3, 0, "R4 word read even");
    read_reg(3, 1, "R4 word read odd address");
    // R6 byte writes in both lanes
    write_reg(3, 1, 16'h7E00, 1, "R6 byte write lane1");
    read_reg(3, 0, "R6 lane1 readback");
    write_reg(5, 0, 16'hFF5A, 0, "R5 word write r5");
    write_reg(5, 0, 16'h0011, 1, "R6 byte write lane0");
    read_reg(5, 0, "R6 lane0 readback");

    // R2: misses
    addr_phase(reg_addr(3, 0), 0, 0, 0);
    wr_phase(0, 16'h1234, 0, "R2 no bank write");
    rd_phase(0, 16'h0, "R2 no bank read");
    end_cycle();
    addr_phase(BASEA - 22'd2, 1, 0, 0);
    wr_phase(0, 16'h1234, 0, "R2 below window");
    end_cycle();
    addr_phase(reg_addr(NR, 0), 1, 0, 0);
    wr_phase(0, 16'h1234, 0, "R2 above window");
    end_cycle();
    read_all("R2 registers untouched");

    // R3: interrupt acknowledge ignored
    addr_phase(reg_addr(3, 0), 1, 1, 0);
    rd_phase(0, 16'h0, "R3 iack read");
    wr_phase(0, 16'hDEAD, 0, "R3 iack write");
    end_cycle();
    read_reg(3, 0, "R3 register untouched");

    // R7: read-modify-write
    write_reg(2, 0, 16'h1357, 0, "R7 preset");
    addr_phase(reg_addr(2, 1), 1, 0, 0);
    rd_phase(1, 16'h1357, "R7 rmw read phase");
    wr_phase(1, 16'hAB00, 1, "R7 rmw write phase");
    end_cycle();
    model[2] = merge_model(model[2], 16'hAB00, 1, 1);
    read_reg(2, 0, "R7 rmw result");

    // R8/R9: block mode writes past the end, then read back
    addr_phase(reg_addr(5, 0), 1, 0, 1);
    wr_phase(1, 16'h5555, 0, "R8 burst write 0");
    wr_phase(1, 16'h6666, 0, "R8 burst write 1");
    wr_phase(1, 16'h7777, 0, "R8 burst write 2");
    wr_phase(0, 16'h8888, 0, "R9 burst overrun write");
    end_cycle();
    model[5] = 16'h5555; model[6] = 16'h6666; model[7] = 16'h7777;
    addr_phase(reg_addr(5, 0), 1, 0, 1);
    rd_phase(1, model[5], "R8 burst read 0");
    rd_phase(1, model[6], "R8 burst read 1");
    rd_phase(1, model[7], "R8 burst read 2");
    rd_phase(0, 16'h0, "R9 burst overrun read");
    end_cycle();
    read_all("R9 registers after overrun");

    // random mix
    for (int n = 0; n < 160; n++) begin
      int op, i, len;
      bit lane, isb;
      bit [15:0] d;
      op = int'($urandom_range(0, 5));
      i = int'($urandom_range(0, NR - 1));
      lane = 1'($urandom_range(0, 1));
      isb = 1'($urandom_range(0, 1));
      d = 16'($urandom);
      case (op)
        0: write_reg(i, lane, d, 0, "R5 random word write");
        1: write_reg(i, lane, d, 1, "R6 random byte write");
        2: read_reg(i, lane, "R4 random read");
        3: begin
          addr_phase(reg_addr(i, lane), 1, 0, 0);
          rd_phase(1, model[i], "R7 random rmw read");
          wr_phase(1, d, isb, "R7 random rmw write");
          end_cycle();
          model[i] = merge_model(model[i], d, isb, lane);
        end
        4: begin
          len = int'($urandom_range(1, 4));
          addr_phase(reg_addr(i, 0), 1, 0, 1);
          for (int k = 0; k < len; k++) begin
            if (i + k < NR) rd_phase(1, model[i + k], "R8 random burst read");
            else            rd_phase(0, 16'h0, "R9 random burst overrun");
          end
          end_cycle();
        end
        default: begin
          addr_phase(reg_addr(i, lane), 0, isb, 0);
          wr_phase(0, d, 0, "R2 random miss write");
          end_cycle();
          read_reg(i, 0, "R2 random miss readback");
        end
      endcase
    end
    read_all("R6 final register state");
    summary();
    $finish;
  end
endmodule